// File: doc/BRIEF.md
# Banked-Register Serial Transmitter

This block is a byte-wide serial transmitter that a host drives through a small register port. The port has a 3-bit offset, a write strobe with write data, and a read strobe with read data. The host does four things through it. It sets the frame format and the baud divisor. It writes bytes to a single holding register. It polls a status register or waits for an interrupt request. Each byte leaves on the `tx` pin as one low start bit, eight data bits least-significant first, and one high stop bit.

Bit timing comes from a reference tick input, `ref_tick`. The divisor scales that tick down to an oversampling tick, and sixteen oversampling ticks make one bit. Bit 7 of the line-format register is a bank-select bit. While it is set, the two lowest offsets reach the divisor bytes in place of the data and interrupt-enable registers. A driver can run in polled mode, waiting on the empty flag, or in interrupt mode, where an enabled interrupt fires whenever the holding register can take another byte.

Top module: `banked_uart_tx`

## Requirements
- R1: After reset, `tx` is 1, `out2` is 0 and `irq` is 0. Offset 5 reads 0x60. Offsets 1, 3 and 4 read 0x00. The divisor reads back as 0x0001: low byte 0x01 at offset 0 and high byte 0x00 at offset 1, both read with bit 7 of offset 3 set.
- R2: While bit 7 of the line-format register (offset 3) is 1, offset 0 reads and writes the divisor low byte and offset 1 reads and writes the divisor high byte. A write to offset 0 in this state starts no frame, and offset 5 still reads 0x60.
- R3: While bit 7 of offset 3 is 0, a write to offset 0 sends a byte and a read of offset 0 returns 0x00. Offset 1 reaches the interrupt-enable register, where only bit 1 is stored. Writing 0xFF there reads back 0x02.
- R4: A frame is a low start bit, then data bits 0 through 7, then a high stop bit. Each bit lasts 16*D pulses of `ref_tick`, where D is the 16-bit divisor. A divisor of 0 behaves as 1.
- R5: A write to offset 0 while the transmitter is idle starts the start bit in the next cycle. After that write, offset 5 reads 0x20: bit 5 (holding empty) is 1 and bit 6 (transmitter idle) is 0.
- R6: A write to offset 0 while a frame is in progress holds the byte, and offset 5 reads 0x00. That byte's start bit follows the previous stop bit with no idle gap, and bit 5 returns to 1 at that point.
- R7: Once the last stop bit has ended and no byte is held, offset 5 reads 0x60 and `tx` stays 1.
- R8: `irq` is 1 exactly when bit 1 of the interrupt-enable register is 1 and bit 5 of offset 5 is 1. It falls in the cycle after a write that fills the holding register, or after a write of 0 to offset 1.
- R9: Bit 3 of the modem-control register (offset 4) drives `out2` from the cycle after the write. The register reads back as written.
- R10: Offset 3 reads back as written. Writes to offset 2 and offset 5 change no other register. Offsets 2, 6 and 7 read 0x00.
- R11: `rd_data` is 0x00 whenever `rd_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick | input | 1 | Reference rate pulse, one clock wide |
| addr | input | 3 | Register offset |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Read data, combinational from offset |
| tx | output | 1 | Serial output, idles high |
| out2 | output | 1 | General output from modem-control bit 3 |
| irq | output | 1 | Transmit-ready interrupt request |

## Verification
The hardest state to reach from the ports is a frame in flight with a second byte waiting in the holding register. This is the only state in which status reads 0x00 and the interrupt is low while it is enabled. To reach it, the bench writes a second byte two cycles after the first. It then follows the serial line across both frames on one cycle counter, which confirms that the second start bit follows the first stop bit with no gap. It reads status and the interrupt just before and just after the hand-over.

// File: rtl/banked_uart_tx.sv
`timescale 1ns/1ps
module banked_uart_tx #(
  parameter int OS_RATIO = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_tick,
  input  logic [2:0] addr,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       rd_en,
  output logic [7:0] rd_data,
  output logic       tx,
  output logic       out2,
  output logic       irq
);
  localparam int DIV_W      = 16;
  localparam int PH_W       = (OS_RATIO > 1) ? $clog2(OS_RATIO) : 1;
  localparam int FRAME_BITS = 10;
  localparam int BC_W       = $clog2(FRAME_BITS + 1);

  logic [7:0]       fmt_q;
  logic             txie_q;
  logic [7:0]       mctl_q;
  logic [DIV_W-1:0] div_q;
  logic [7:0]       hold_q;
  logic             hold_full;
  logic             busy;
  logic [FRAME_BITS-1:0] sh_q;
  logic [BC_W-1:0]  bits_left;
  logic [DIV_W-1:0] rate_cnt;
  logic [PH_W-1:0]  phase;

  wire              bank = fmt_q[7];
  wire              wr_thr = wr_en && (addr == 3'd0) && !bank;
  wire [DIV_W-1:0]  div_eff = (div_q == '0) ? DIV_W'(1) : div_q;
  wire              os_tick = busy && ref_tick && (rate_cnt == div_eff - DIV_W'(1));
  wire              bit_end = os_tick && (phase == PH_W'(OS_RATIO - 1));
  wire              finish = bit_end && (bits_left == BC_W'(1));
  wire              reload = finish && hold_full;
  wire              direct = wr_thr && (!busy || finish) && !reload;
  wire              thr_empty = !hold_full;
  wire              all_idle = !busy && !hold_full;

  assign tx   = sh_q[0];
  assign out2 = mctl_q[3];
  assign irq  = txie_q && thr_empty;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fmt_q  <= 8'h00;
      txie_q <= 1'b0;
      mctl_q <= 8'h00;
      div_q  <= DIV_W'(1);
    end else if (wr_en) begin
      case (addr)
        3'd0: if (bank) div_q[7:0] <= wr_data;
        3'd1: if (bank) div_q[15:8] <= wr_data;
              else txie_q <= wr_data[1];
        3'd3: fmt_q  <= wr_data;
        3'd4: mctl_q <= wr_data;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rate_cnt <= '0;
      phase    <= '0;
    end else if (!busy || reload || direct) begin
      rate_cnt <= '0;
      phase    <= '0;
    end else if (ref_tick) begin
      if (os_tick) begin
        rate_cnt <= '0;
        phase    <= phase + PH_W'(1);
      end else begin
        rate_cnt <= rate_cnt + DIV_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      sh_q      <= '1;
      bits_left <= '0;
      hold_q    <= 8'h00;
      hold_full <= 1'b0;
    end else if (reload) begin
      sh_q      <= {1'b1, hold_q, 1'b0};
      bits_left <= BC_W'(FRAME_BITS);
      hold_full <= wr_thr;
      if (wr_thr) hold_q <= wr_data;
    end else if (direct) begin
      sh_q      <= {1'b1, wr_data, 1'b0};
      bits_left <= BC_W'(FRAME_BITS);
      busy      <= 1'b1;
    end else begin
      if (wr_thr) begin
        hold_q    <= wr_data;
        hold_full <= 1'b1;
      end
      if (bit_end) begin
        sh_q      <= {1'b1, sh_q[FRAME_BITS-1:1]};
        bits_left <= bits_left - BC_W'(1);
        if (finish) busy <= 1'b0;
      end
    end
  end

  always_comb begin
    rd_data = 8'h00;
    if (rd_en) begin
      case (addr)
        3'd0: rd_data = bank ? div_q[7:0] : 8'h00;
        3'd1: rd_data = bank ? div_q[15:8] : {6'b0, txie_q, 1'b0};
        3'd3: rd_data = fmt_q;
        3'd4: rd_data = mctl_q;
        3'd5: rd_data = {1'b0, all_idle, thr_empty, 5'b0};
        default: rd_data = 8'h00;
      endcase
    end
  end
endmodule

module banked_uart_tx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] addr,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic       tx,
  input logic       out2,
  input logic       irq,
  input logic       busy,
  input logic       hold_full,
  input logic       bank,
  input logic       txie
);
  a_r4_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !tx);
  a_r7_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> tx);
  a_r6_hold_needs_shifter: assert property (@(posedge clk) disable iff (!rst_n)
    hold_full |-> busy);
  a_r5_idle_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd0 && !bank && !busy) |=> (busy && !hold_full));
  a_r8_irq_drops_on_fill: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_full) |-> !irq);
  a_r8_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> txie);
  a_r9_out2_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd4) |=> (out2 == $past(wr_data[3])));
  a_r2_bank_no_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd0 && bank && !busy) |=> !busy);
endmodule

bind banked_uart_tx banked_uart_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
  .tx(tx), .out2(out2), .irq(irq), .busy(busy), .hold_full(hold_full),
  .bank(fmt_q[7]), .txie(txie_q)
);

// File: tb/banked_uart_tx_tb.sv
`timescale 1ns/1ps
module banked_uart_tx_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_tick = 1'b1;
  logic [2:0] addr = 3'd0;
  logic wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic rd_en = 1'b0;
  logic [7:0] rd_data;
  logic tx, out2, irq;

  int checks = 0;
  int failures = 0;
  int n = 0;
  logic [9:0] got;

  always #4 clk = ~clk;

  banked_uart_tx u_dut (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .addr(addr), .wr_en(wr_en),
    .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data), .tx(tx), .out2(out2), .irq(irq)
  );

  // {op(1=write,2=read), addr, data, expected, requirement}
  localparam int NV = 32;
  localparam logic [24:0] VEC [NV] = '{
    {2'd2, 3'd5, 8'h00, 8'h60, 4'd1},   // R1
    {2'd2, 3'd3, 8'h00, 8'h00, 4'd1},   // R1
    {2'd2, 3'd1, 8'h00, 8'h00, 4'd1},   // R1
    {2'd2, 3'd4, 8'h00, 8'h00, 4'd1},   // R1
    {2'd2, 3'd0, 8'h00, 8'h00, 4'd3},   // R3
    {2'd2, 3'd2, 8'h00, 8'h00, 4'd10},  // R10
    {2'd2, 3'd7, 8'h00, 8'h00, 4'd10},  // R10
    {2'd1, 3'd3, 8'h83, 8'h00, 4'd2},
    {2'd2, 3'd3, 8'h00, 8'h83, 4'd10},  // R10
    {2'd2, 3'd0, 8'h00, 8'h01, 4'd1},   // R1 divisor low
    {2'd2, 3'd1, 8'h00, 8'h00, 4'd1},   // R1 divisor high
    {2'd1, 3'd0, 8'h05, 8'h00, 4'd2},
    {2'd1, 3'd1, 8'h01, 8'h00, 4'd2},
    {2'd2, 3'd0, 8'h00, 8'h05, 4'd2},   // R2
    {2'd2, 3'd1, 8'h00, 8'h01, 4'd2},   // R2
    {2'd2, 3'd5, 8'h00, 8'h60, 4'd2},   // R2 no frame
    {2'd1, 3'd0, 8'h01, 8'h00, 4'd2},
    {2'd1, 3'd1, 8'h00, 8'h00, 4'd2},
    {2'd1, 3'd3, 8'h03, 8'h00, 4'd2},
    {2'd2, 3'd3, 8'h00, 8'h03, 4'd10},  // R10
    {2'd2, 3'd1, 8'h00, 8'h00, 4'd2},   // R2 interrupt enable untouched
    {2'd1, 3'd1, 8'hFF, 8'h00, 4'd3},
    {2'd2, 3'd1, 8'h00, 8'h02, 4'd3},   // R3
    {2'd1, 3'd1, 8'h00, 8'h00, 4'd3},
    {2'd2, 3'd1, 8'h00, 8'h00, 4'd3},   // R3
    {2'd1, 3'd4, 8'h08, 8'h00, 4'd9},
    {2'd2, 3'd4, 8'h00, 8'h08, 4'd9},   // R9
    {2'd1, 3'd2, 8'h00, 8'h00, 4'd10},
    {2'd1, 3'd5, 8'h00, 8'h00, 4'd10},
    {2'd2, 3'd3, 8'h00, 8'h03, 4'd10},  // R10
    {2'd2, 3'd4, 8'h00, 8'h08, 4'd10},  // R10
    {2'd2, 3'd5, 8'h00, 8'h60, 4'd10}   // R10
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    addr = a; rd_en = 1'b1;
    #1 v = rd_data;
    rd_en = 1'b0;
  endtask

  task automatic wait_to(input int target);
    while (n < target) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic capture(input int d, input int base);
    for (int k = 0; k < 10; k++) begin
      wait_to(base + 8 * d + 16 * d * k);
      got[k] = tx;
    end
  endtask

  task automatic set_div(input logic [15:0] d);
    wr(3'd3, 8'h83);
    wr(3'd0, d[7:0]);
    wr(3'd1, d[15:8]);
    wr(3'd3, 8'h03);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(tx == 1'b1, "R1 tx", tx, 1);
    check(out2 == 1'b0, "R1 out2", out2, 0);
    check(irq == 1'b0, "R1 irq", irq, 0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][24:23] == 2'd1) wr(VEC[i][22:20], VEC[i][19:12]);
      else begin
        rd(VEC[i][22:20], v);
        check(v == VEC[i][11:4], $sformatf("R%0d vector %0d", VEC[i][3:0], i), v, VEC[i][11:4]);
      end
    end

    check(out2 == 1'b1, "R9 out2 high", out2, 1);
    wr(3'd4, 8'h00);
    check(out2 == 1'b0, "R9 out2 low", out2, 0);

    addr = 3'd3; rd_en = 1'b0; #1;
    check(rd_data == 8'h00, "R11 no strobe", rd_data, 0);

    wr(3'd1, 8'h02);
    check(irq == 1'b1, "R8 enabled idle", irq, 1);
    wr(3'd1, 8'h00);
    check(irq == 1'b0, "R8 masked", irq, 0);
    wr(3'd1, 8'h02);

    // back-to-back frames at divisor 1
    wr(3'd0, 8'hA7);
    n = 0;
    rd(3'd5, v);
    check(v == 8'h20, "R5 status after idle write", v, 8'h20);
    check(irq == 1'b1, "R8 irq stays on idle write", irq, 1);
    check(tx == 1'b0, "R5 start bit begins", tx, 0);
    wr(3'd0, 8'h5C);
    n = 2;
    rd(3'd5, v);
    check(v == 8'h00, "R6 status with held byte", v, 8'h00);
    check(irq == 1'b0, "R8 irq falls on fill", irq, 0);
    capture(1, 0);
    check(got == {1'b1, 8'hA7, 1'b0}, "R4 frame A", got, {1'b1, 8'hA7, 1'b0});
    rd(3'd5, v);
    check(v == 8'h00, "R6 status before hand-over", v, 8'h00);
    wait_to(160);
    check(tx == 1'b0, "R6 no gap", tx, 0);
    rd(3'd5, v);
    check(v == 8'h20, "R6 empty after hand-over", v, 8'h20);
    check(irq == 1'b1, "R8 irq after hand-over", irq, 1);
    capture(1, 160);
    check(got == {1'b1, 8'h5C, 1'b0}, "R6 frame B", got, {1'b1, 8'h5C, 1'b0});
    wait_to(330);
    rd(3'd5, v);
    check(v == 8'h60, "R7 fully idle", v, 8'h60);
    check(tx == 1'b1, "R7 line high", tx, 1);
    wr(3'd1, 8'h00);

    // divisor 2
    set_div(16'd2);
    wr(3'd0, 8'h96);
    n = 0;
    capture(2, 0);
    check(got == {1'b1, 8'h96, 1'b0}, "R4 divisor 2 frame", got, {1'b1, 8'h96, 1'b0});
    wait_to(16 * 2 * 9 + 8 * 2 - 1);
    check(tx == 1'b1, "R4 stop bit held", tx, 1);
    wait_to(16 * 2 * 10 + 4);
    rd(3'd5, v);
    check(v == 8'h60, "R4 divisor 2 length", v, 8'h60);

    // divisor 0 behaves as 1
    set_div(16'd0);
    wr(3'd0, 8'h3C);
    n = 0;
    capture(1, 0);
    check(got == {1'b1, 8'h3C, 1'b0}, "R4 divisor 0 frame", got, {1'b1, 8'h3C, 1'b0});
    wait_to(164);
    rd(3'd5, v);
    check(v == 8'h60, "R4 divisor 0 length", v, 8'h60);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule